// File: doc/BRIEF.md
# Three-Channel Fan PWM Generator with Manual Override

The block drives three fan PWM pins from one shared 256-step period counter. Software reaches it through a plain parallel register port: each channel has a configuration byte and a duty byte. The top three bits of the configuration byte select the channel's behaviour. The value `3'b111` hands the duty to software. Any other value takes the duty from an external automatic-control input bus.

A read of a duty address always returns the duty that is being applied to the pin, whatever the mode. From reset, every channel drives its pin constantly high (full fan speed). A channel stays there until software writes its configuration byte for the first time. Duty changes are adopted only at a period boundary, so a pulse is never cut short or stretched mid-period.

Top module: `fan_pwm_bank`

## Requirements
- R1: After reset every `pwm_out` bit is constantly high, every duty address (0x30, 0x31, 0x32 for channels 0, 1, 2) reads 0xFF, and every configuration address reads 0x00.
- R2: A write to configuration address 0x5C, 0x5D or 0x5E (channels 0, 1, 2) stores the whole byte, which reads back unchanged. That write also marks the channel as configured. A channel that has never been configured keeps full duty, independently of the other channels.
- R3: A configured channel whose configuration bits [7:5] equal 3'b111 is in manual mode and applies the last byte written to its duty address. That stored byte is 0x00 after reset.
- R4: A configured channel in any other mode applies its byte of `auto_duty` (channel i uses bits [8i+7:8i]). Writes to its duty address in that mode are discarded and are not stored.
- R5: For an applied duty D, a pin is high for exactly D of every 256 counter ticks. D = 0xFF gives a constantly high pin and D = 0x00 a constantly low pin.
- R6: A new duty value takes effect only at the start of a PWM period. Until then the previous duty stays applied and is the value read back.
- R7: Reading a duty address returns the applied duty in manual and automatic modes alike.
- R8: A read of any address outside the six channel registers returns 0x00.
- R9: The period counter advances once per tick, and a tick occurs every `TICK_DIV` clocks, so one period lasts 256 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register address for reads and writes |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| auto_duty | input | 8*NUM_CH | Duty bytes from the automatic controller, channel i at [8i+7:8i] |
| pwm_out | output | NUM_CH | Fan PWM pins |

## Verification
If the applied-duty register holds a wrong value, the error shows at the ports in two ways. The pin's high time over any 256-tick window is wrong, and the duty readback is wrong, both within one period of the fault. If the channel's configured flag or its mode decode is wrong, the channel tracks the wrong source, either the stored byte, the auto input or full speed. That shows on the next period boundary. A write that lands in a non-manual channel's storage stays hidden until the channel is switched to manual mode. The bench therefore makes that switch and then inspects the pin and the readback. A boundary-timing fault shows only as a readback that changes early. The bench samples it mid-period, at a phase it finds from a known pulse.

// File: rtl/fpwm_pkg.sv
// Shared constants for the fan PWM bank: register windows and mode code.
// Assumes an 8-bit register address space and 8-bit duty values.
package fpwm_pkg;
    localparam int          DUTY_W         = 8;
    localparam logic [7:0]  ADDR_DUTY_BASE = 8'h30;
    localparam logic [7:0]  ADDR_CFG_BASE  = 8'h5C;
    localparam logic [2:0]  MODE_MANUAL    = 3'b111;
    localparam logic [7:0]  DUTY_FULL      = 8'hFF;
    typedef logic [DUTY_W-1:0] duty_t;
endpackage

// File: rtl/fpwm_period.sv
// Tick prescaler plus the shared 8-bit PWM period counter.
// Assumes TICK_DIV >= 1; with TICK_DIV == 1 every clock is a tick.
module fpwm_period #(
    parameter int TICK_DIV = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic       tick,
    output logic [7:0] cnt
);
    generate
        if (TICK_DIV == 1) begin : g_notdiv
            assign tick = 1'b1;
        end else begin : g_div
            localparam int DIV_W = $clog2(TICK_DIV);
            logic [DIV_W-1:0] pre_q;
            // Count clocks and emit one tick per TICK_DIV clocks.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pre_q <= '0;
                else if (pre_q == DIV_W'(TICK_DIV - 1))
                    pre_q <= '0;
                else
                    pre_q <= pre_q + 1'b1;
            end
            assign tick = (pre_q == DIV_W'(TICK_DIV - 1));
        end
    endgenerate

    // Advance the period position once per tick, wrapping at 256.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= 8'h00;
        else if (tick)
            cnt <= cnt + 8'h01;
    end
endmodule

// File: rtl/fpwm_regs.sv
// Register file: per-channel configuration byte, stored manual duty and
// configured flag, plus the combinational read mux. Duty writes are
// accepted only while the channel's mode field selects manual control.
module fpwm_regs
    import fpwm_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [7:0]               addr,
    input  logic                     wr_en,
    input  logic [7:0]               wdata,
    input  logic [NUM_CH-1:0][7:0]   applied,
    output logic [7:0]               rdata,
    output logic [NUM_CH-1:0][7:0]   duty_sw,
    output logic [NUM_CH-1:0]        manual,
    output logic [NUM_CH-1:0]        configured
);
    logic [NUM_CH-1:0][7:0] cfg_q;

    // Capture configuration and manual-duty writes per channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            duty_sw    <= '0;
            configured <= '0;
        end else if (wr_en) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (addr == ADDR_CFG_BASE + 8'(c)) begin
                    cfg_q[c]      <= wdata;
                    configured[c] <= 1'b1;
                end
                if (addr == ADDR_DUTY_BASE + 8'(c) && manual[c])
                    duty_sw[c] <= wdata;
            end
        end
    end

    // Decode the behaviour field of each channel.
    always_comb begin
        for (int c = 0; c < NUM_CH; c++)
            manual[c] = (cfg_q[c][7:5] == MODE_MANUAL);
    end

    // Return config bytes and applied duties; zero elsewhere.
    always_comb begin
        rdata = 8'h00;
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr == ADDR_CFG_BASE + 8'(c))
                rdata = cfg_q[c];
            if (addr == ADDR_DUTY_BASE + 8'(c))
                rdata = applied[c];
        end
    end
endmodule

// File: rtl/fpwm_chan.sv
// One PWM channel: latches its target duty at each period start and
// compares it with the shared counter. Duty 0xFF is held constantly high.
module fpwm_chan
    import fpwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wrap,
    input  logic [7:0] cnt,
    input  logic [7:0] target,
    output logic [7:0] applied,
    output logic       pwm
);
    // Adopt a new duty only as the counter rolls over to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            applied <= DUTY_FULL;
        else if (wrap)
            applied <= target;
    end

    // Drive the pin high while the counter is below the duty.
    assign pwm = (applied == DUTY_FULL) || (cnt < applied);
endmodule

// File: rtl/fan_pwm_bank.sv
// Top of the fan PWM bank: register file, shared period counter and
// NUM_CH channels. Each channel's target is full duty until it is
// configured, then either the software duty or its auto_duty byte.
module fan_pwm_bank
    import fpwm_pkg::*;
#(
    parameter int NUM_CH   = 3,
    parameter int TICK_DIV = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            reg_addr,
    input  logic                  reg_wr,
    input  logic [7:0]            reg_wdata,
    output logic [7:0]            reg_rdata,
    input  logic [NUM_CH*8-1:0]   auto_duty,
    output logic [NUM_CH-1:0]     pwm_out
);
    logic                   tick;
    logic [7:0]             cnt;
    logic                   wrap;
    logic [NUM_CH-1:0][7:0] applied;
    logic [NUM_CH-1:0][7:0] duty_sw;
    logic [NUM_CH-1:0][7:0] target;
    logic [NUM_CH-1:0]      manual;
    logic [NUM_CH-1:0]      configured;

    fpwm_period #(.TICK_DIV(TICK_DIV)) period_i (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .cnt  (cnt)
    );

    // Last tick of a period: next counter value is zero.
    assign wrap = tick && (cnt == 8'hFF);

    fpwm_regs #(.NUM_CH(NUM_CH)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (reg_addr),
        .wr_en     (reg_wr),
        .wdata     (reg_wdata),
        .applied   (applied),
        .rdata     (reg_rdata),
        .duty_sw   (duty_sw),
        .manual    (manual),
        .configured(configured)
    );

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            // Select the duty source for this channel.
            always_comb begin
                if (!configured[g])
                    target[g] = DUTY_FULL;
                else if (manual[g])
                    target[g] = duty_sw[g];
                else
                    target[g] = auto_duty[g*8 +: 8];
            end

            fpwm_chan chan_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .wrap   (wrap),
                .cnt    (cnt),
                .target (target[g]),
                .applied(applied[g]),
                .pwm    (pwm_out[g])
            );
        end
    endgenerate
endmodule

// File: rtl/fpwm_checker.sv
// Assertion checker for fan_pwm_bank, attached by bind below.
// Observes the counter, tick, applied duties and configured flags.
module fpwm_checker #(
    parameter int NUM_CH = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   tick,
    input logic [7:0]             cnt,
    input logic [NUM_CH-1:0][7:0] applied,
    input logic [NUM_CH-1:0]      configured,
    input logic [NUM_CH-1:0]      pwm_out
);
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> cnt == $past(cnt) + 8'd1);                     // R9
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));                                // R9

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
            AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !(tick && cnt == 8'hFF) |=> $stable(applied[g]));   // R6
            AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
                applied[g] == 8'hFF |-> pwm_out[g]);                // R5
            AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                applied[g] == 8'h00 |-> !pwm_out[g]);               // R5
            AST_UNCONF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
                !configured[g] |-> applied[g] == 8'hFF);            // R2
        end
    endgenerate
endmodule

bind fan_pwm_bank fpwm_checker #(.NUM_CH(NUM_CH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cnt       (cnt),
    .applied   (applied),
    .configured(configured),
    .pwm_out   (pwm_out)
);

// File: tb/fan_pwm_bank_tb_top.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset, independence, discarded writes, boundary timing and
// unmapped reads.
module fan_pwm_bank_tb_top;
    localparam int NUM_CH = 3;
    localparam int NVEC   = 7;

    // Fields: ch[42:41] cfg[40:33] duty[32:25] auto[24:17] hi[16:8] rd[7:0]
    localparam logic [42:0] VEC [NVEC] = '{
        {2'd0, 8'hE0, 8'h80, 8'h00, 9'd128, 8'h80},   // R3 half duty
        {2'd0, 8'hE0, 8'h54, 8'h00, 9'd84,  8'h54},   // R3 third duty
        {2'd1, 8'h60, 8'h11, 8'h40, 9'd64,  8'h40},   // R4 R7 auto source
        {2'd1, 8'h60, 8'h22, 8'hC0, 9'd192, 8'hC0},   // R4 R7 auto source
        {2'd2, 8'hFF, 8'hFF, 8'h00, 9'd256, 8'hFF},   // R5 full
        {2'd2, 8'hE0, 8'h00, 8'h00, 9'd0,   8'h00},   // R5 zero
        {2'd0, 8'h1F, 8'h99, 8'h01, 9'd1,   8'h01}    // R4 manual to auto
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [7:0]          reg_addr = 8'h00;
    logic                reg_wr = 1'b0;
    logic [7:0]          reg_wdata = 8'h00;
    logic [7:0]          reg_rdata;
    logic [NUM_CH*8-1:0] auto_duty = '0;
    logic [NUM_CH-1:0]   pwm_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    fan_pwm_bank #(.NUM_CH(NUM_CH), .TICK_DIV(1)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .auto_duty(auto_duty),
        .pwm_out  (pwm_out)
    );

    // Record one comparison and report a mismatch.
    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // Issue one register write, driven at the falling edge.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    // Read a register combinationally away from the clock edge.
    task automatic rd(input logic [7:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1 v = int'(reg_rdata);
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Count high samples of one pin over 256 ticks (one period, R9).
    task automatic count_high(input int ch, output int hi);
        hi = 0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (pwm_out[ch]) hi++;
        end
    endtask

    initial begin
        int v;
        int hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int c = 0; c < NUM_CH; c++) begin
            count_high(c, hi);
            check("R1 pin full after reset", hi, 256);
            rd(8'h30 + 8'(c), v);
            check("R1 duty readback after reset", v, 8'hFF);
            rd(8'h5C + 8'(c), v);
            check("R1 config readback after reset", v, 8'h00);
        end

        // R2/R3: configuring ch0 manual uses stored duty 0x00; ch1 stays full
        wr(8'h5C, 8'hE0);
        wait_cycles(600);
        count_high(0, hi);
        check("R3 reset duty storage is zero", hi, 0);
        count_high(1, hi);
        check("R2 unconfigured channel stays full", hi, 256);
        rd(8'h31, v);
        check("R2 unconfigured readback full", v, 8'hFF);

        // Vector table
        for (int k = 0; k < NVEC; k++) begin
            int ch;
            ch = int'(VEC[k][42:41]);
            wr(8'h5C + 8'(ch), VEC[k][40:33]);
            wr(8'h30 + 8'(ch), VEC[k][32:25]);
            auto_duty[ch*8 +: 8] = VEC[k][24:17];
            wait_cycles(600);
            count_high(ch, hi);
            check("R5 high ticks per period", hi, int'(VEC[k][16:8]));
            rd(8'h30 + 8'(ch), v);
            check("R7 applied duty readback", v, int'(VEC[k][7:0]));
            rd(8'h5C + 8'(ch), v);
            check("R2 config byte readback", v, int'(VEC[k][40:33]));
        end

        // R4: writes to ch1 in auto mode were discarded; manual shows 0x00
        wr(8'h5D, 8'hE0);
        wait_cycles(600);
        count_high(1, hi);
        check("R4 discarded auto-mode writes", hi, 0);
        rd(8'h31, v);
        check("R4 discarded auto-mode readback", v, 8'h00);

        // R6: duty change waits for the period start
        wr(8'h32, 8'h01);
        wait_cycles(600);
        @(negedge clk);
        while (pwm_out[2]) @(negedge clk);
        while (!pwm_out[2]) @(negedge clk);
        reg_addr  = 8'h31;
        reg_wdata = 8'hA0;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
        wait_cycles(100);
        rd(8'h31, v);
        check("R6 old duty held mid-period", v, 8'h00);
        wait_cycles(200);
        rd(8'h31, v);
        check("R6 new duty after boundary", v, 8'hA0);
        count_high(1, hi);
        check("R5 duty 0xA0 high ticks", hi, 160);

        // R8: unmapped addresses
        rd(8'h00, v);
        check("R8 unmapped 0x00", v, 0);
        rd(8'h33, v);
        check("R8 unmapped 0x33", v, 0);
        rd(8'h5F, v);
        check("R8 unmapped 0x5F", v, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule